// File: doc/BRIEF.md
# Infrared remote transmit modulator

This block drives the output pin of an infrared remote-control transmitter. Software chooses one level at a time, mark or space, through a data bit. It also sets how long that level lasts by loading an 8-bit length value. The length counts down on ticks of a slow counter clock. A free-running prescaler divides the system clock to make that tick, and a register field picks the division. While the data bit is 1, the pin carries a carrier wave made in the block from separate high and low periods. While the data bit is 0, the pin stays low.

When the length counter reaches zero, a sticky flag is set and, if enabled, the interrupt line rises. Software then loads the next level and length. The carrier periods, the tick selection and the interrupt enable are fixed while the block runs. Writes to them are dropped until the enable bit is cleared.

Top module: `irtx_modulator`

## Requirements
- R1: After reset `ir_out` and `irq` are low and every register reads back as zero.
- R2: `ir_out` is a register that follows (enable AND mode==0 AND data AND carrier) one system clock late. The control register at address 0 holds enable in bit 0, mode in bit 1 (0 = transmit) and data in bit 2. If data is 0, mode is 1 or enable is 0, the pin is low.
- R3: The carrier register at address 2 holds the high period in bits 5:0 and the low period in bits 13:8, both in system clocks, with 0 taken as 1. The carrier is high for the high period and then low for the low period, repeating. It starts at the beginning of a high phase in the first cycle in which enable is 1.
- R4: The timer register at address 3 holds the tick select in bits 3:0. The prescaler is cleared while disabled and counts while enabled. With k = min(select, PRE_W-2), it gives a single-cycle tick every 2^(k+1) system clocks. The first tick comes 2^(k+1)-1 cycles after the first enabled cycle.
- R5: A write to the length register at address 1 (bits 7:0) loads the counter at once, whether the block is enabled or not. Reading that address returns the current count. While enabled, the count drops by one on each tick and then holds at zero until it is written again.
- R6: The interrupt flag (address 3, bit 8) is set when a tick takes the count from 1 to 0. Loading 0 never sets it. The flag stays set until a 1 is written to bit 8, and a clear write is accepted while enabled.
- R7: `irq` is the flag ANDed with the interrupt enable (address 3, bit 4).
- R8: While enable is 1, writes to the carrier periods, the tick select and the interrupt enable are ignored, and their read-back values stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ir_out | output | 1 | Modulated transmit pin |
| irq | output | 1 | Length underflow interrupt |

## Verification
The bench builds the block with PRE_W=8, so the widest tap is divide-by-128. Every tick select, including the clamped ones above 6, therefore finishes its countdown in a few hundred cycles. The bench sweeps high periods 0 to 4 against low periods 1 to 4, which covers the zero-as-one rule and each phase boundary cycle by cycle. It follows the length count after every clock for several selects and lengths, so the exact underflow edge, the hold at zero and the gating of the flag are all checked.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LEN   = 2'd1,
    REG_CARR  = 2'd2,
    REG_TIMER = 2'd3
  } reg_addr_e;

  // highest prescaler bit index that gates the tick, clamped to the counter
  function automatic int tap_index(input int sel, input int pre_w);
    return (sel > pre_w - 2) ? pre_w - 2 : sel;
  endfunction

  // a zero carrier period is treated as one clock
  function automatic int eff_period(input int p);
    return (p == 0) ? 1 : p;
  endfunction
endpackage

// File: rtl/irtx_prescaler.sv
module irtx_prescaler
  import irtx_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i <= tap_index(int'(sel), PRE_W)) mask[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else             cnt <= cnt + 1'b1;

  assign tick = en && ((cnt & mask) == mask);

  // divide-by-2 is the fastest tap, so ticks are never back to back
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick spacing");
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
  import irtx_pkg::*;
#(
  parameter int CAR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CAR_W-1:0] hi_per,
  input  logic [CAR_W-1:0] lo_per,
  output logic             carrier_hi
);
  logic             phase_hi;
  logic [CAR_W-1:0] cnt;
  logic [CAR_W-1:0] hi_len, lo_len, cur_len;
  logic             phase_end;

  assign hi_len    = CAR_W'(eff_period(int'(hi_per)));
  assign lo_len    = CAR_W'(eff_period(int'(lo_per)));
  assign cur_len   = phase_hi ? hi_len : lo_len;
  assign phase_end = (cnt == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
    end else if (!en) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
    end else if (phase_end) begin
      phase_hi <= !phase_hi;
      cnt      <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end

  assign carrier_hi = phase_hi;

  assert_carrier_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> carrier_hi) else $error("carrier not restarted high");
  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < cur_len)) else $error("carrier count beyond period");
endmodule

// File: rtl/irtx_lencnt.sv
module irtx_lencnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  output logic [LEN_W-1:0] count,
  output logic             underflow
);
  logic step;

  assign step      = en && tick && !load && (count != '0);
  assign underflow = step && (count == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count - 1'b1;

  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> (count == '0)) else $error("count wrapped");
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !load) |=> (count == $past(count) || count == LEN_W'($past(count) - 1'b1)))
    else $error("count jumped");
endmodule

// File: rtl/irtx_modulator.sv
module irtx_modulator
  import irtx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int CAR_W  = 6,
  parameter int PRE_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ir_out,
  output logic              irq
);
  localparam int LO_LSB   = 8;
  localparam int IE_BIT   = 4;
  localparam int FLAG_BIT = 8;

  logic             en_q, mode_q, data_q;
  logic [CAR_W-1:0] hi_q, lo_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q, out_q;
  logic             wr_ctrl, wr_len, wr_carr, wr_timer;
  logic             tick, carrier_hi, underflow;
  logic [LEN_W-1:0] count;
  logic             unused_wr_bits;

  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
  assign wr_len   = wr_en && (wr_addr == REG_LEN);
  assign wr_carr  = wr_en && (wr_addr == REG_CARR);
  assign wr_timer = wr_en && (wr_addr == REG_TIMER);
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= 1'b0; data_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= wr_data[0]; mode_q <= wr_data[1]; data_q <= wr_data[2];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0;
    end else if (wr_carr && !en_q) begin
      hi_q <= wr_data[CAR_W-1:0];
      lo_q <= wr_data[LO_LSB +: CAR_W];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0; ie_q <= 1'b0;
    end else if (wr_timer && !en_q) begin
      sel_q <= wr_data[SEL_W-1:0];
      ie_q  <= wr_data[IE_BIT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              flag_q <= 1'b0;
    else if (underflow)                      flag_q <= 1'b1;
    else if (wr_timer && wr_data[FLAG_BIT])  flag_q <= 1'b0;

  irtx_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en_q), .sel(sel_q), .tick(tick));

  irtx_carrier #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_n), .en(en_q), .hi_per(hi_q), .lo_per(lo_q),
    .carrier_hi(carrier_hi));

  irtx_lencnt #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .load(wr_len),
    .load_val(wr_data[LEN_W-1:0]), .count(count), .underflow(underflow));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= en_q && !mode_q && data_q && carrier_hi;

  assign ir_out = out_q;
  assign irq    = flag_q && ie_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      REG_CTRL:  rd_data[2:0] = {data_q, mode_q, en_q};
      REG_LEN:   rd_data[LEN_W-1:0] = count;
      REG_CARR: begin
        rd_data[CAR_W-1:0]        = hi_q;
        rd_data[LO_LSB +: CAR_W]  = lo_q;
      end
      default: begin
        rd_data[SEL_W-1:0] = sel_q;
        rd_data[IE_BIT]    = ie_q;
        rd_data[FLAG_BIT]  = flag_q;
      end
    endcase
  end

  assert_out_low_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_q) |-> !ir_out) else $error("pin high while disabled");
  assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(count) == LEN_W'(1))) else $error("flag without underflow");
  assert_config_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> ($stable(hi_q) && $stable(lo_q) && $stable(sel_q) && $stable(ie_q)))
    else $error("config changed while enabled");
  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ie_q && flag_q)) else $error("irq without enable");
endmodule

// File: tb/tb_irtx_modulator.sv
`timescale 1ns/1ps
module tb_irtx_modulator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ir_out, irq;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  irtx_modulator #(.PRE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ir_out(ir_out), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // returns at the negedge following the capturing posedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  function automatic int divisor(input int sel);
    int k;
    k = (sel > 6) ? 6 : sel;
    return 1 << (k + 1);
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int v, he, per, d, n, e;
    int sels[5];
    int lens[2];
    sels = '{0, 1, 2, 3, 7};
    lens = '{1, 3};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ir_out", int'(ir_out), 0);
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register", v, 0);
    end

    // R3 / R2 carrier sweep
    for (int h = 0; h <= 4; h++) begin
      for (int l = 1; l <= 4; l++) begin
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'((l << 8) | h));
        wr(2'd0, 16'h0005);
        he  = (h == 0) ? 1 : h;
        per = he + l;
        for (int k = 1; k <= 2 * per + 2; k++) begin
          @(negedge clk);
          check("R3 carrier waveform", int'(ir_out), (((k - 1) % per) < he) ? 1 : 0);
        end
      end
    end

    // R2 data 0, mode 1, disable
    wr(2'd0, 16'h0001);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R2 data low", int'(ir_out), 0);
    end
    wr(2'd0, 16'h0007);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R2 mode 1", int'(ir_out), 0);
    end
    wr(2'd0, 16'h0005);
    wr(2'd0, 16'h0004);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R2 disabled", int'(ir_out), 0);
    end

    // R4 / R5 / R6 / R7 length counter sweep
    foreach (sels[si]) begin
      foreach (lens[ni]) begin
        n = lens[ni];
        d = divisor(sels[si]);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'(16'h0110 | sels[si]));
        wr(2'd1, 16'(n));
        wr(2'd0, 16'h0001);
        for (int k = 1; k <= n * d + 3; k++) begin
          @(negedge clk);
          e = n - k / d;
          if (e < 0) e = 0;
          rd(2'd1, v);
          check("R4 R5 count", v, e);
          check("R6 R7 irq timing", int'(irq), (k >= n * d) ? 1 : 0);
        end
        rd(2'd3, v);
        check("R6 flag sticky", (v >> 8) & 1, 1);
        // clear while enabled; sel/ie bits in this write must be ignored
        wr(2'd3, 16'h0100);
        check("R6 clear", int'(irq), 0);
        rd(2'd3, v);
        check("R8 timer locked", v, 16'h0010 | sels[si]);
      end
    end

    // R5 reload after underflow, and load of zero raises nothing
    wr(2'd1, 16'd2);
    rd(2'd1, v);
    check("R5 reload", v, 2);
    wr(2'd1, 16'd0);
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      check("R6 zero load no irq", int'(irq), 0);
    end
    rd(2'd3, v);
    check("R6 zero load no flag", (v >> 8) & 1, 0);

    // R7 interrupt enable off
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0100);
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h0001);
    repeat (4) @(negedge clk);
    rd(2'd3, v);
    check("R7 flag set", (v >> 8) & 1, 1);
    check("R7 irq masked", int'(irq), 0);

    // R8 carrier write ignored while enabled, accepted when disabled
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0402);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h0303);
    rd(2'd2, v);
    check("R8 carrier locked", v, 16'h0402);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0303);
    rd(2'd2, v);
    check("R8 carrier open", v, 16'h0303);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule